// File: doc/BRIEF.md
# Programmable Remote Output Controller

This block sits behind a remote-control word receiver. Each time the receiver raises its ready flag, the block takes the accepted 5-bit word and updates five outputs. A 6-bit strap word picks the mode, and the mode decides how each output reacts and whether the receiver must be addressed first.

There are three modes:

- **Direct mode.** The word lands on the outputs one for one.
- **Two-bit addressed mode.** Each word sets or clears a single chosen output on one of up to four receivers.
- **Four-bit addressed mode.** Address words select one receiver out of sixteen, and data words then drive four outputs of the selected receiver.

Within each mode the strap word also marks which outputs are momentary. A momentary output follows only the triggering word's ready period. The other outputs hold their value. An enable input gates all five outputs to zero without disturbing the stored state.

Bit mapping is the same throughout. `word_i[4:0]` carries word bits e, d, c, b, a, with `word_i[0]` = a. `out_o[0]` is output a and `out_o[4]` is output e.

Top module: `rmt_out_ctrl`

## Requirements
- R1: While `rst_ni` is low, all outputs, all held state and the four-bit-mode selection are cleared. After reset the receiver is unselected.
- R2: Direct mode is `ctrl_i` = 000000, 000001, 000011, 000111, 001111 or 011111. A held output takes its word bit when a word is accepted and keeps it until the next accepted word.
- R3: In direct mode, each set bit of `ctrl_i[4:0]` makes the matching output momentary, filled from a upward. A momentary output equals its word bit while `ready_i` stays high, and is 0 from the cycle after `ready_i` falls.
- R4: Two-bit mode is `ctrl_i[5:2]` = 0010, 0100, 0101 or 0110, with receiver address `ctrl_i[1:0]`. A word whose bits b,a differ from that address changes nothing.
- R5: In two-bit mode, word bits d,c pick the output (00 picks a, 01 b, 10 c, 11 d). With e = 0 the picked output is set, or pulsed if it is momentary. With e = 1 a held output is cleared and a momentary one is unaffected.
- R6: In two-bit mode, `ctrl_i[5:2]` = 0010 makes no output momentary, and 0100, 0101 and 0110 make one, two and three outputs momentary, starting from a.
- R7: Four-bit mode is `ctrl_i[5]` = 1, with address `ctrl_i[3:0]`. A word with e = 0 selects the receiver when d,c,b,a equals the address and deselects it otherwise. A word with e = 1 drives outputs d..a only while the receiver is selected.
- R8: In four-bit mode, `ctrl_i[4]` = 0 makes outputs a..d held and `ctrl_i[4]` = 1 makes them momentary.
- R9: Output e stays 0 in both addressed modes. Any `ctrl_i` value not listed in R2, R4 or R7 clears all outputs, all held state and the selection.
- R10: `oe_i` = 0 forces `out_o` to 0. Returning `oe_i` to 1 restores the stored values.
- R11: A word is accepted only on the first clock edge with `ready_i` high after it was low. Outputs change one cycle after acceptance, and word changes while `ready_i` stays high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| word_i | input | 5 | Accepted word, bits e..a at [4:0] |
| ready_i | input | 1 | High while the current word is valid |
| ctrl_i | input | 6 | Strap word selecting mode, momentary set and address |
| oe_i | input | 1 | Output enable, 0 forces all outputs off |
| out_o | output | 5 | Outputs e..a at [4:0] |

## Verification
Several rules are checked on every cycle by assertions:

- held outputs keep their value whenever no word is accepted and the strap word is unchanged;
- momentary outputs are released once ready has been low;
- output e stays dark outside direct mode;
- an unlisted strap word clears the stored state;
- a mismatching address word drops the four-bit selection;
- a two-bit-mode word touches at most one output.

Other behaviour only shows up across whole scenarios run by the bench against its reference model. This covers the address matching and the set, pulse and clear choice of each word. It also covers data words ignored while the receiver is unselected, the momentary counts for each strap code, enable gating, and reset dropping the selection.

// File: rtl/rmt_pkg.sv
package rmt_pkg;
  localparam int OUT_W  = 5;
  localparam int WORD_W = 5;
  localparam int CTRL_W = 6;
  localparam int ADDR_W = 4;
  localparam int SEL_W  = 2;   // output-select field width in two-bit mode
  localparam int A2_W   = 2;   // receiver address width in two-bit mode
  localparam int E_BIT  = WORD_W - 1;

  typedef enum logic [1:0] {
    MD_NONE   = 2'd0,
    MD_DIRECT = 2'd1,
    MD_ADDR2  = 2'd2,
    MD_ADDR4  = 2'd3
  } mode_e;

  typedef struct packed {
    mode_e              mode;
    logic [OUT_W-1:0]   mom_mask;
    logic [OUT_W-1:0]   valid_mask;
    logic [ADDR_W-1:0]  addr;
  } cfg_t;
endpackage

// File: rtl/rmt_ctrl_decode.sv
module rmt_ctrl_decode
  import rmt_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl_i,
  output cfg_t              cfg_o
);
  localparam logic [OUT_W-1:0] ALL_M  = {OUT_W{1'b1}};
  localparam logic [OUT_W-1:0] LOW4_M = ALL_M >> 1;

  logic [OUT_W-1:0] low_bits;
  logic             is_therm;

  assign low_bits = ctrl_i[OUT_W-1:0];
  // thermometer code 0..01..1: adding one clears every set bit
  assign is_therm = ((low_bits & (low_bits + OUT_W'(1))) == '0);

  always_comb begin
    cfg_o = '0;
    cfg_o.mode = MD_NONE;
    if (ctrl_i[CTRL_W-1]) begin
      cfg_o.mode       = MD_ADDR4;
      cfg_o.valid_mask = LOW4_M;
      cfg_o.mom_mask   = ctrl_i[ADDR_W] ? LOW4_M : '0;
      cfg_o.addr       = ctrl_i[ADDR_W-1:0];
    end else if (is_therm) begin
      cfg_o.mode       = MD_DIRECT;
      cfg_o.valid_mask = ALL_M;
      cfg_o.mom_mask   = low_bits;
    end else begin
      unique case (ctrl_i[CTRL_W-1:A2_W])
        4'b0010: begin cfg_o.mode = MD_ADDR2; cfg_o.mom_mask = '0;              end
        4'b0100: begin cfg_o.mode = MD_ADDR2; cfg_o.mom_mask = OUT_W'(5'b00001); end
        4'b0101: begin cfg_o.mode = MD_ADDR2; cfg_o.mom_mask = OUT_W'(5'b00011); end
        4'b0110: begin cfg_o.mode = MD_ADDR2; cfg_o.mom_mask = OUT_W'(5'b00111); end
        default: cfg_o.mode = MD_NONE;
      endcase
      if (cfg_o.mode == MD_ADDR2) begin
        cfg_o.valid_mask = LOW4_M;
        cfg_o.addr       = ADDR_W'(ctrl_i[A2_W-1:0]);
      end
    end
  end
endmodule

// File: rtl/rmt_word_action.sv
module rmt_word_action
  import rmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mode_e             mode_i,
  input  logic [OUT_W-1:0]  mom_mask_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [OUT_W-1:0]  latch_q_i,
  input  logic              sel_q_i,
  output logic [OUT_W-1:0]  latch_d_o,
  output logic [OUT_W-1:0]  pulse_o,
  output logic              sel_d_o
);
  logic [OUT_W-1:0] tgt;
  logic             e_bit;
  logic             a2_hit;

  assign e_bit  = word_i[E_BIT];
  assign a2_hit = (word_i[A2_W-1:0] == addr_i[A2_W-1:0]);

  always_comb begin
    tgt = '0;
    tgt[word_i[A2_W+SEL_W-1:A2_W]] = 1'b1;
  end

  always_comb begin
    latch_d_o = latch_q_i;
    pulse_o   = '0;
    sel_d_o   = sel_q_i;
    unique case (mode_i)
      MD_DIRECT: begin
        latch_d_o = word_i & ~mom_mask_i;
        pulse_o   = word_i & mom_mask_i;
      end
      MD_ADDR2: begin
        if (a2_hit) begin
          if (!e_bit) begin
            if ((tgt & mom_mask_i) != '0) pulse_o   = tgt;
            else                          latch_d_o = latch_q_i | tgt;
          end else begin
            latch_d_o = latch_q_i & ~(tgt & ~mom_mask_i);
          end
        end
      end
      MD_ADDR4: begin
        if (!e_bit) begin
          sel_d_o = (word_i[ADDR_W-1:0] == addr_i);
        end else if (sel_q_i) begin
          if (mom_mask_i[0]) pulse_o   = OUT_W'(word_i[ADDR_W-1:0]);
          else               latch_d_o = OUT_W'(word_i[ADDR_W-1:0]);
        end
      end
      default: begin
        latch_d_o = '0;
        sel_d_o   = 1'b0;
      end
    endcase
  end

  AST_ADDR2_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MD_ADDR2) |-> $onehot0((latch_q_i ^ latch_d_o) | pulse_o)); // R5
endmodule

// File: rtl/rmt_out_state.sv
module rmt_out_state
  import rmt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             ready_i,
  input  mode_e            mode_i,
  input  logic [OUT_W-1:0] valid_mask_i,
  input  logic [OUT_W-1:0] mom_mask_i,
  input  logic [OUT_W-1:0] latch_d_i,
  input  logic [OUT_W-1:0] pulse_i,
  input  logic             sel_d_i,
  output logic [OUT_W-1:0] latch_q_o,
  output logic [OUT_W-1:0] mom_q_o,
  output logic             sel_q_o
);
  logic [OUT_W-1:0] keep_mask;
  assign keep_mask = valid_mask_i & ~mom_mask_i;

  for (genvar i = 0; i < OUT_W; i++) begin : g_out
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       latch_q_o[i] <= 1'b0;
      else if (accept_i) latch_q_o[i] <= latch_d_i[i] & keep_mask[i];
      else               latch_q_o[i] <= latch_q_o[i] & keep_mask[i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       mom_q_o[i] <= 1'b0;
      else if (accept_i) mom_q_o[i] <= pulse_i[i];
      else if (!ready_i) mom_q_o[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 sel_q_o <= 1'b0;
    else if (mode_i != MD_ADDR4) sel_q_o <= 1'b0;
    else if (accept_i)           sel_q_o <= sel_d_i;
  end
endmodule

// File: rtl/rmt_out_ctrl.sv
module rmt_out_ctrl
  import rmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              ready_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              oe_i,
  output logic [OUT_W-1:0]  out_o
);
  cfg_t             cfg;
  logic             rdy_q;
  logic             accept;
  logic [OUT_W-1:0] latch_q, mom_q, latch_d, pulse;
  logic             sel_q, sel_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_q <= 1'b0;
    else         rdy_q <= ready_i;
  end
  assign accept = ready_i & ~rdy_q;

  rmt_ctrl_decode u_decode (
    .ctrl_i (ctrl_i),
    .cfg_o  (cfg)
  );

  rmt_word_action u_action (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (cfg.mode),
    .mom_mask_i (cfg.mom_mask),
    .addr_i     (cfg.addr),
    .word_i     (word_i),
    .latch_q_i  (latch_q),
    .sel_q_i    (sel_q),
    .latch_d_o  (latch_d),
    .pulse_o    (pulse),
    .sel_d_o    (sel_d)
  );

  rmt_out_state u_state (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .accept_i     (accept),
    .ready_i      (ready_i),
    .mode_i       (cfg.mode),
    .valid_mask_i (cfg.valid_mask),
    .mom_mask_i   (cfg.mom_mask),
    .latch_d_i    (latch_d),
    .pulse_i      (pulse),
    .sel_d_i      (sel_d),
    .latch_q_o    (latch_q),
    .mom_q_o      (mom_q),
    .sel_q_o      (sel_q)
  );

  assign out_o = (latch_q | (mom_q & cfg.mom_mask)) & cfg.valid_mask & {OUT_W{oe_i}};

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!accept && $stable(ctrl_i)) |=> $stable(latch_q)); // R2
  AST_MOM_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!ready_i) && $stable(ctrl_i)) |-> ((out_o & cfg.mom_mask) == '0)); // R3
  AST_SEL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && cfg.mode == MD_ADDR4 && !word_i[E_BIT] && word_i[ADDR_W-1:0] != cfg.addr)
    |=> !sel_q); // R7
  AST_E_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.mode != MD_DIRECT) |-> !out_o[E_BIT]); // R9
  AST_NONE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.mode == MD_NONE) |=> (latch_q == '0 && !sel_q)); // R9
endmodule

// File: tb/rmt_out_ctrl_tb.sv
module rmt_out_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] word_i = '0;
  logic       ready_i = 1'b0;
  logic [5:0] ctrl_i = '0;
  logic       oe_i = 1'b1;
  logic [4:0] out_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rmt_out_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .word_i(word_i), .ready_i(ready_i),
    .ctrl_i(ctrl_i), .oe_i(oe_i), .out_o(out_o)
  );

  // reference model state
  int m_lat, m_mom, m_sel, m_rdy;

  function automatic void mdl_cfg(input int c, output int md, output int mm,
                                  output int vm, output int ad);
    md = 0; mm = 0; vm = 0; ad = 0;
    if (c >= 32) begin
      md = 3; vm = 15; ad = c % 16; mm = ((c / 16) % 2 == 1) ? 15 : 0;
    end else if (c inside {0, 1, 3, 7, 15, 31}) begin
      md = 1; vm = 31; mm = c;
    end else begin
      case (c / 4)
        2: begin md = 2; mm = 0; end
        4: begin md = 2; mm = 1; end
        5: begin md = 2; mm = 3; end
        6: begin md = 2; mm = 7; end
        default: md = 0;
      endcase
      if (md == 2) begin vm = 15; ad = c % 4; end
    end
  endfunction

  function automatic int mdl_out();
    int md, mm, vm, ad;
    mdl_cfg(int'(ctrl_i), md, mm, vm, ad);
    if (!oe_i) return 0;
    return (m_lat | (m_mom & mm)) & vm;
  endfunction

  function automatic string mode_req();
    int md, mm, vm, ad;
    mdl_cfg(int'(ctrl_i), md, mm, vm, ad);
    case (md)
      1: return "R2";
      2: return "R5";
      3: return "R7";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk) begin
    int md, mm, vm, ad, w, e, sel_bit, acc;
    if (!rst_ni) begin
      m_lat = 0; m_mom = 0; m_sel = 0; m_rdy = 0;
    end else begin
      mdl_cfg(int'(ctrl_i), md, mm, vm, ad);
      w = int'(word_i); e = w / 16;
      acc = (ready_i && !m_rdy) ? 1 : 0;
      if (acc == 1) begin
        m_mom = 0;
        if (md == 1) begin
          m_lat = w & ~mm; m_mom = w & mm;
        end else if (md == 2 && (w % 4) == ad) begin
          sel_bit = 1 << ((w / 4) % 4);
          if (e == 0) begin
            if ((sel_bit & mm) != 0) m_mom = sel_bit;
            else m_lat = m_lat | sel_bit;
          end else if ((sel_bit & mm) == 0) begin
            m_lat = m_lat & ~sel_bit;
          end
        end else if (md == 3) begin
          if (e == 0) m_sel = ((w % 16) == ad) ? 1 : 0;
          else if (m_sel == 1) begin
            if (mm != 0) m_mom = w % 16;
            else m_lat = w % 16;
          end
        end
      end else if (!ready_i) begin
        m_mom = 0;
      end
      m_lat = m_lat & vm & ~mm;
      if (md != 3) m_sel = 0;
      m_rdy = ready_i ? 1 : 0;
      #1;
      checks++;
      if (int'(out_o) != mdl_out()) begin
        failures++;
        $display("FAIL %s model compare: got %05b expected %05b", mode_req(), out_o, 5'(mdl_out()));
      end
    end
  end

  task automatic chk(input logic [4:0] exp, input string req);
    checks++;
    if (out_o !== exp) begin
      failures++;
      $display("FAIL %s: got %05b expected %05b", req, out_o, exp);
    end
  endtask

  task automatic set_ctrl(input logic [5:0] c);
    ctrl_i = c;
    @(negedge clk);
    @(negedge clk);
  endtask

  // send one word, check while ready is high and after it drops
  task automatic send(input logic [4:0] w, input logic [4:0] exp_hi,
                      input logic [4:0] exp_lo, input string req);
    word_i = w; ready_i = 1'b1;
    @(negedge clk);
    chk(exp_hi, req);
    ready_i = 1'b0;
    @(negedge clk);
    chk(exp_lo, req);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL R11 watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(5'b00000, "R1");
    rst_ni = 1'b1;
    @(negedge clk);
    chk(5'b00000, "R1");

    // direct, all held
    send(5'b10110, 5'b10110, 5'b10110, "R2");
    oe_i = 1'b0; @(negedge clk); chk(5'b00000, "R10");
    oe_i = 1'b1; @(negedge clk); chk(5'b10110, "R10");

    // accept only on rising ready
    word_i = 5'b00001; ready_i = 1'b1;
    @(negedge clk); chk(5'b00001, "R11");
    word_i = 5'b11000;
    @(negedge clk); chk(5'b00001, "R11");
    ready_i = 1'b0;
    @(negedge clk); chk(5'b00001, "R11");

    // direct with momentary a,b then all momentary
    set_ctrl(6'b000011);
    send(5'b10111, 5'b10111, 5'b10100, "R3");
    set_ctrl(6'b011111);
    send(5'b11111, 5'b11111, 5'b00000, "R3");

    // unlisted code clears state
    set_ctrl(6'b000000);
    send(5'b11111, 5'b11111, 5'b11111, "R2");
    set_ctrl(6'b000010);
    chk(5'b00000, "R9");
    set_ctrl(6'b000000);
    chk(5'b00000, "R9");

    // two-bit mode, all held, address 10
    set_ctrl(6'b001010);
    send(5'b01010, 5'b00100, 5'b00100, "R5");
    send(5'b00110, 5'b00110, 5'b00110, "R5");
    send(5'b01101, 5'b00110, 5'b00110, "R4");
    send(5'b11010, 5'b00010, 5'b00010, "R5");

    // two-bit mode, a,b momentary
    set_ctrl(6'b010110);
    chk(5'b00000, "R6");
    send(5'b00110, 5'b00010, 5'b00000, "R6");
    send(5'b10010, 5'b00000, 5'b00000, "R5");
    send(5'b01110, 5'b01000, 5'b01000, "R6");

    // four-bit mode, held, address 0101
    set_ctrl(6'b100101);
    send(5'b11111, 5'b01000, 5'b01000, "R7");
    send(5'b00101, 5'b01000, 5'b01000, "R7");
    send(5'b10011, 5'b00011, 5'b00011, "R7");
    send(5'b00110, 5'b00011, 5'b00011, "R7");
    send(5'b11100, 5'b00011, 5'b00011, "R7");
    send(5'b00101, 5'b00011, 5'b00011, "R7");
    send(5'b11100, 5'b01100, 5'b01100, "R7");

    // four-bit mode, momentary
    set_ctrl(6'b110101);
    chk(5'b00000, "R8");
    send(5'b11010, 5'b01010, 5'b00000, "R8");
    send(5'b11111, 5'b01111, 5'b00000, "R9");

    // reset drops held state and selection
    set_ctrl(6'b100101);
    send(5'b10001, 5'b00001, 5'b00001, "R7");
    rst_ni = 1'b0;
    @(negedge clk); chk(5'b00000, "R1");
    rst_ni = 1'b1;
    @(negedge clk);
    send(5'b11111, 5'b00000, 5'b00000, "R1");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule